// File: doc/BRIEF.md
# Oversampled asynchronous serial receiver with error flags

This block receives asynchronous serial frames on a single line. A sample-enable tick arrives at sixteen times the bit rate. The receiver watches the idle line for a low level. It then samples every bit in the middle of its period and shifts in seven or eight data bits, least significant bit first. An optional parity bit follows, and then one or two stop bits. When the first stop bit has been sampled, the frame is judged. The data is moved to a holding register, and four sticky status flags are updated: data-full, overrun, framing error and parity error.

Software empties the holding register and acknowledges errors through four write-one clear strobes. Two level interrupts are produced, one for received data and one for errors, and a single enable gates both. While any error flag is set, the receiver ignores the line. This prevents a backlog of bad frames from building up behind an unattended error.

Top module: `serial_rx_err`

## Requirements
- R1: After reset, `rx_data` is zero, all four flags are zero and both interrupts are low.
- R2: With no error flag set, a tick that sees `rxd` low starts a frame, and that tick is index 0 of the start bit. Each bit is sampled on its tick index 7, which is the eighth tick, and later bits are sampled every 16 ticks. If the start bit samples high, the frame is abandoned with no flag change, and the receiver returns to watching the line.
- R3: Data bits arrive least significant first. With `cfg_short`=1, seven bits are received and `rx_data[7]` reads 0. With `cfg_short`=0, eight bits are received.
- R4: With `cfg_par_en`=1, one parity bit follows the data. The XOR of the data bits and the parity bit must equal `cfg_par_odd`, where 1 means odd and 0 means even, or `par_err` is set. With `cfg_par_en`=0, no parity bit is expected and `par_err` is never set.
- R5: `frm_err` is set when the first stop bit samples 0. With `cfg_stop2`=1, the second stop bit is sampled but its value is ignored.
- R6: A frame that has no parity or stop error and arrives while `full` is 0 loads `rx_data` and sets `full`.
- R7: A frame with a parity or stop error that arrives while `full` is 0 still loads `rx_data`, but it leaves `full` at 0.
- R8: A frame that completes while `full` is 1 sets `ovr_err`, and `rx_data` keeps its previous value.
- R9: While any of `ovr_err`, `frm_err` or `par_err` is 1, no new frame starts, so `rx_data` and `full` are not changed by line activity.
- R10: A one-cycle pulse on `clr_full`, `clr_ovr`, `clr_frm` or `clr_par` clears the matching flag. A flag that is set and cleared in the same cycle ends up set.
- R11: `irq_rx` equals `full` AND `irq_en`. `irq_err` equals (`ovr_err` OR `frm_err` OR `par_err`) AND `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle sample enable at 16x the bit rate |
| rxd | input | 1 | Serial line, already synchronised; idle high |
| cfg_short | input | 1 | 1 selects seven data bits, 0 selects eight |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 for odd parity, 0 for even |
| cfg_stop2 | input | 1 | Two stop bits |
| irq_en | input | 1 | Shared interrupt enable |
| clr_full | input | 1 | Write-one clear of the data-full flag |
| clr_ovr | input | 1 | Write-one clear of the overrun flag |
| clr_frm | input | 1 | Write-one clear of the framing flag |
| clr_par | input | 1 | Write-one clear of the parity flag |
| rx_data | output | DW | Holding register |
| full | output | 1 | Data-full flag |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |
| irq_rx | output | 1 | Receive-data interrupt |
| irq_err | output | 1 | Receive-error interrupt |

## Verification
The bench builds the block with its defaults: 16 ticks per bit, mid-sample on the eighth tick and eight data bits. It sweeps all sixteen combinations of data length, parity enable, parity sense and stop count. For each combination it sends good frames, an overrun pair, a frame sent while the receiver is frozen, a bad stop bit, a flipped parity bit, and a clear strobe that lands on the completing tick. The second stop bit is always driven low, which shows that it is never checked. A short low pulse on the idle line exercises the rejection of a false start.

// File: rtl/serial_rx_err.sv
module serial_rx_err #(
  parameter int OSR       = 16,
  parameter int SAMPLE_AT = 8,
  parameter int DW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          cfg_short,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_stop2,
  input  logic          irq_en,
  input  logic          clr_full,
  input  logic          clr_ovr,
  input  logic          clr_frm,
  input  logic          clr_par,
  output logic [DW-1:0] rx_data,
  output logic          full,
  output logic          ovr_err,
  output logic          frm_err,
  output logic          par_err,
  output logic          irq_rx,
  output logic          irq_err
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW + 1);
  localparam logic [CW-1:0] MID  = CW'(SAMPLE_AT - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] NB_LONG  = BW'(DW - 1);
  localparam logic [BW-1:0] NB_SHORT = BW'(DW - 2);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_STOP2} st_t;

  st_t           state;
  logic [CW-1:0] phase;
  logic [BW-1:0] nbit;
  logic [DW-1:0] sh;
  logic          par_acc;

  wire any_err  = ovr_err | frm_err | par_err;
  wire start_ok = tick && state == S_IDLE && !rxd && !any_err;
  wire mid      = tick && state != S_IDLE && phase == MID;
  wire done     = mid && state == S_STOP;
  wire stop_bad = !rxd;
  wire p_bad    = cfg_par_en && (par_acc != cfg_par_odd);
  wire last_bit = nbit == (cfg_short ? NB_SHORT : NB_LONG);
  wire [DW-1:0] word = cfg_short ? (sh >> 1) : sh;

  wire set_full = done && !full && !stop_bad && !p_bad;
  wire set_ovr  = done && full;
  wire set_frm  = done && stop_bad;
  wire set_par  = done && p_bad;
  wire load     = done && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      phase   <= '0;
      nbit    <= '0;
      sh      <= '0;
      par_acc <= 1'b0;
    end else begin
      if (start_ok) begin
        state <= S_START;
        phase <= CW'(1);
      end else if (tick && state != S_IDLE) begin
        phase <= (phase == LAST) ? '0 : phase + CW'(1);
      end
      if (mid) begin
        unique case (state)
          S_START: begin
            nbit    <= '0;
            par_acc <= 1'b0;
            state   <= rxd ? S_IDLE : S_DATA;
          end
          S_DATA: begin
            sh      <= {rxd, sh[DW-1:1]};
            par_acc <= par_acc ^ rxd;
            nbit    <= nbit + BW'(1);
            if (last_bit) state <= cfg_par_en ? S_PAR : S_STOP;
          end
          S_PAR: begin
            par_acc <= par_acc ^ rxd;
            state   <= S_STOP;
          end
          S_STOP:  state <= cfg_stop2 ? S_STOP2 : S_IDLE;
          S_STOP2: state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      full    <= 1'b0;
      ovr_err <= 1'b0;
      frm_err <= 1'b0;
      par_err <= 1'b0;
    end else begin
      if (load) rx_data <= word;
      full    <= set_full | (full    & ~clr_full);
      ovr_err <= set_ovr  | (ovr_err & ~clr_ovr);
      frm_err <= set_frm  | (frm_err & ~clr_frm);
      par_err <= set_par  | (par_err & ~clr_par);
    end
  end

  assign irq_rx  = full & irq_en;
  assign irq_err = any_err & irq_en;
endmodule

module serial_rx_err_chk #(parameter int DW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_en,
  input logic          clr_full,
  input logic          clr_ovr,
  input logic          clr_frm,
  input logic          clr_par,
  input logic [DW-1:0] rx_data,
  input logic          full,
  input logic          ovr_err,
  input logic          frm_err,
  input logic          par_err,
  input logic          irq_rx,
  input logic          irq_err
);
  assert_full_clear_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(clr_full));
  assert_ovr_clear_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_err) |-> $past(clr_ovr));
  assert_frm_clear_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frm_err) |-> $past(clr_frm));
  assert_par_clear_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(par_err) |-> $past(clr_par));
  assert_overrun_keeps_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $stable(rx_data));
  assert_error_blocks_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frm_err) || $rose(par_err)) |-> !$rose(full));
  assert_frozen_no_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err || frm_err || par_err) |=> ($stable(rx_data) && !$rose(full)));
  assert_rx_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> (full && irq_en));
  assert_err_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (irq_en && (ovr_err || frm_err || par_err)));
endmodule

bind serial_rx_err serial_rx_err_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_serial_rx_err.sv
module tb_serial_rx_err;
  logic clk = 0, rst_n = 0, tick = 0, rxd = 1;
  logic cfg_short = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_stop2 = 0, irq_en = 0;
  logic clr_full = 0, clr_ovr = 0, clr_frm = 0, clr_par = 0;
  logic [7:0] rx_data;
  logic full, ovr_err, frm_err, par_err, irq_rx, irq_err;
  int checks = 0, errors = 0, cyc = 0;
  logic done_flag = 0;

  always #4 clk = ~clk;

  serial_rx_err dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000 && !done_flag) begin
      errors++;
      $display("FAIL watchdog: act %0d exp 0", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic one_tick(input logic v, input logic clr);
    @(negedge clk);
    rxd = v; tick = 1; clr_full = clr;
    @(negedge clk);
    tick = 0; clr_full = 0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_full = 1; clr_ovr = 1; clr_frm = 1; clr_par = 1;
    @(negedge clk);
    clr_full = 0; clr_ovr = 0; clr_frm = 0; clr_par = 0;
  endtask

  // sends one frame; second stop bit is held low through its sample point
  task automatic send(input logic [7:0] d, input bit pflip, input bit sbad, input bit clr_done);
    logic [11:0] bits;
    int n, nd, stop_i;
    logic [7:0] dm;
    logic p;
    nd = cfg_short ? 7 : 8;
    dm = cfg_short ? (d & 8'h7F) : d;
    p  = (^dm) ^ cfg_par_odd ^ pflip;
    n = 0;
    bits[n++] = 1'b0;
    for (int i = 0; i < nd; i++) bits[n++] = dm[i];
    if (cfg_par_en) bits[n++] = p;
    stop_i = n;
    bits[n++] = !sbad;
    if (cfg_stop2) bits[n++] = 1'b0;
    for (int b = 0; b < n; b++)
      for (int t = 0; t < 16; t++) begin
        logic v;
        v = bits[b];
        if (cfg_stop2 && b == n - 1 && t >= 8) v = 1'b1;
        one_tick(v, clr_done && b == stop_i && t == 7);
      end
    for (int t = 0; t < 3; t++) one_tick(1'b1, 1'b0);
  endtask

  function automatic logic [7:0] expd(input logic [7:0] d);
    return cfg_short ? (d & 8'h7F) : d;
  endfunction

  initial begin
    logic [7:0] pats [4];
    logic [7:0] d1, d2;
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;
    repeat (3) @(negedge clk);
    check(rx_data == 0 && !full && !ovr_err && !frm_err && !par_err && !irq_rx && !irq_err,
          "R1 reset", {rx_data, full, ovr_err, frm_err, par_err}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int c = 0; c < 16; c++) begin
      cfg_short = c[0]; cfg_par_en = c[1]; cfg_par_odd = c[2]; cfg_stop2 = c[3];
      clear_all();
      for (int k = 0; k < 4; k++) begin
        logic [7:0] d;
        d = pats[k] ^ 8'(c * 37);
        irq_en = k[0];
        send(d, 0, 0, 0);
        check(rx_data == expd(d), "R3 data order", rx_data, expd(d));
        check(full && !ovr_err && !frm_err && !par_err, "R6 R5 good frame", {full, ovr_err, frm_err, par_err}, 4'b1000);
        check(irq_rx == irq_en && !irq_err, "R11 irq", {irq_rx, irq_err}, {irq_en, 1'b0});
        clear_all();
        check(!full && !irq_rx, "R10 clear full", full, 0);
      end
      irq_en = 1;
      d1 = 8'h3C ^ 8'(c);
      d2 = 8'hC3 ^ 8'(c);
      send(d1, 0, 0, 0);
      send(d2, 0, 0, 0);
      check(ovr_err && full && rx_data == expd(d1), "R8 overrun keeps data", rx_data, expd(d1));
      check(irq_err, "R11 err irq", irq_err, 1);
      @(negedge clk); clr_full = 1; @(negedge clk); clr_full = 0;
      send(d2, 0, 0, 0);
      check(!full && ovr_err && rx_data == expd(d1), "R9 frozen", {full, rx_data}, {1'b0, expd(d1)});
      @(negedge clk); clr_ovr = 1; @(negedge clk); clr_ovr = 0;
      check(!ovr_err && !irq_err, "R10 clear ovr", ovr_err, 0);
      send(d2, 0, 0, 0);
      check(full && rx_data == expd(d2), "R9 resume", rx_data, expd(d2));
      clear_all();
      send(d2, 0, 1, 0);
      check(frm_err && !full && rx_data == expd(d2), "R7 R5 framing", {frm_err, full}, 2'b10);
      @(negedge clk); clr_frm = 1; @(negedge clk); clr_frm = 0;
      check(!frm_err, "R10 clear frm", frm_err, 0);
      send(d1, 1, 0, 0);
      if (cfg_par_en)
        check(par_err && !full && rx_data == expd(d1), "R4 R7 parity", {par_err, full, rx_data}, {2'b10, expd(d1)});
      else
        check(!par_err && full && rx_data == expd(d1), "R4 no parity", {par_err, full}, 2'b01);
      clear_all();
      send(d2, 0, 0, 1);
      check(full, "R10 set wins", full, 1);
      clear_all();
    end

    cfg_short = 0; cfg_par_en = 0; cfg_stop2 = 0;
    for (int t = 0; t < 4; t++) one_tick(1'b0, 1'b0);
    for (int t = 0; t < 24; t++) one_tick(1'b1, 1'b0);
    check(!full && !frm_err && !ovr_err && !par_err, "R2 glitch no flags", {full, frm_err}, 0);
    send(8'h96, 0, 0, 0);
    check(full && rx_data == 8'h96, "R2 after glitch", rx_data, 8'h96);

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule